// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a 32-bit virtual address into a physical address after a miss in the translation cache. It takes one request at a time, checks the virtual page number against a table-length bound, and then performs two dependent 4-byte reads through a single memory read port. The first read fetches an outer-table entry. That entry points at an inner table, and the second read fetches the inner-table entry that holds the frame number. It returns the frame number and permission bits so that the translation cache can be filled, together with the finished physical address. A walk can also end in one of three faults.

The virtual address splits into three fields: bits [31:22] are the outer index, bits [21:12] are the inner index, and bits [11:0] are the byte offset. The virtual page number is bits [31:12]. Every table entry is 32 bits wide, with the following layout:

- bit 31 is the valid flag;
- bits [22:3] are a 20-bit frame number;
- bits [2:0] are permissions (read, write, execute).

A table read address is the table base plus four times the index. The outer base comes from the root input. The inner base is the outer entry's frame field shifted left by 12.

The walk is a single state machine:

- **IDLE**: waits for a request.
  - On a request whose page number exceeds the length bound, go to DONE.
  - On any other request, go to OUTER_REQ.
- **OUTER_REQ**: offers the outer read. Go to OUTER_WAIT on acceptance.
- **OUTER_WAIT**: waits for the outer entry.
  - If the entry is valid, go to INNER_REQ.
  - If the entry is invalid, go to DONE.
- **INNER_REQ**: offers the inner read. Go to INNER_WAIT on acceptance.
- **INNER_WAIT**: waits for the inner entry, then goes to DONE.
- **DONE**: shows the result for one cycle, then returns to IDLE.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and `done`, `mem_req_valid` and all fault outputs are 0.
- R2: A request whose page number (vaddr[31:12]) is greater than `tbl_len` completes with `fault_len`, and no memory read is issued for it.
- R3: The first read address is `root_base + 4*vaddr[31:22]`.
- R4: The second read address is `{outer_entry[22:3], 12'h000} + 4*vaddr[21:12]`. It is issued only after the outer response has been received.
- R5: An outer entry with bit 31 clear ends the walk with `fault_outer` after exactly one read.
- R6: An inner entry with bit 31 clear ends the walk with `fault_inner` after exactly two reads. On that result, `frame`, `perm` and `paddr` are 0.
- R7: A walk in which both entries are valid ends with no fault flag.
  - `frame` is inner_entry[22:3].
  - `perm` is inner_entry[2:0].
  - `paddr` is `{frame, vaddr[11:0]}`.
- R8: `req_ready` is 1 only in IDLE. It stays 0 from the cycle after acceptance through the DONE cycle.
- R9: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request and its address hold steady.
- R10: `done` is a single-cycle pulse, followed by IDLE. At most one fault flag is set, and fault flags are set only together with `done`.
- R11: A page number equal to `tbl_len` is legal and is walked normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Walk request |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| req_vaddr | input | 32 | Virtual address to translate |
| root_base | input | 32 | Physical base of the outer table |
| tbl_len | input | 20 | Highest legal virtual page number |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Table read byte address |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Table entry |
| done | output | 1 | Walk finished (one cycle) |
| frame | output | 20 | Resolved frame number |
| perm | output | 3 | Permission bits from inner entry |
| paddr | output | 32 | Resolved physical address |
| fault_len | output | 1 | Page number beyond the length bound |
| fault_outer | output | 1 | Outer entry invalid |
| fault_inner | output | 1 | Inner entry invalid |

## Verification
The bench builds the walker with its default widths: a 32-bit virtual and physical address and a 10/10/12 split. This puts the extreme indices within reach, so outer and inner index 1023 and offset 0xFFF are walked and the top table entry at base+4092 is fetched. With a 20-bit length register, the bound can be set to exactly the requested page number, and to the full 0xFFFFF. A page that would otherwise fault at the inner level is placed just past the bound, which shows that the length check wins and no read is issued. The memory model varies its acceptance pattern and response latency, which exercises the hold rule on the read port.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OUTER_REQ,
        ST_OUTER_WAIT,
        ST_INNER_REQ,
        ST_INNER_WAIT,
        ST_DONE
    } walk_state_t;

    typedef enum logic [1:0] {
        FLT_NONE,
        FLT_LENGTH,
        FLT_OUTER,
        FLT_INNER
    } walk_fault_t;

endpackage

// File: rtl/ptw_entry_decode.sv
module ptw_entry_decode #(
    parameter int ENTRY_W = 32,
    parameter int FRAME_W = 20,
    parameter int PERM_W  = 3
) (
    input  logic [ENTRY_W-1:0] entry,
    output logic               ent_valid,
    output logic [FRAME_W-1:0] ent_frame,
    output logic [PERM_W-1:0]  ent_perm
);
    // valid flag on top, frame sits directly above the permission bits
    assign ent_valid = entry[ENTRY_W-1];
    assign ent_frame = entry[PERM_W +: FRAME_W];
    assign ent_perm  = entry[PERM_W-1:0];
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
    parameter int PA_W  = 32,
    parameter int IDX_W = 10,
    parameter int SHIFT = 2
) (
    input  logic [PA_W-1:0]  base,
    input  logic [IDX_W-1:0] idx,
    output logic [PA_W-1:0]  addr
);
    localparam int PAD_W = PA_W - IDX_W;

    assign addr = base + ({{PAD_W{1'b0}}, idx} << SHIFT);
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
#(
    parameter int VA_W    = 32,
    parameter int PA_W    = 32,
    parameter int OFF_W   = 12,
    parameter int OUT_W   = 10,
    parameter int PERM_W  = 3,
    parameter int ENTRY_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [VA_W-1:0]         req_vaddr,
    input  logic [PA_W-1:0]         root_base,
    input  logic [VA_W-OFF_W-1:0]   tbl_len,
    output logic                    mem_req_valid,
    input  logic                    mem_req_ready,
    output logic [PA_W-1:0]         mem_req_addr,
    input  logic                    mem_rsp_valid,
    input  logic [ENTRY_W-1:0]      mem_rsp_data,
    output logic                    done,
    output logic [PA_W-OFF_W-1:0]   frame,
    output logic [PERM_W-1:0]       perm,
    output logic [PA_W-1:0]         paddr,
    output logic                    fault_len,
    output logic                    fault_outer,
    output logic                    fault_inner
);
    localparam int IN_W    = VA_W - OFF_W - OUT_W;
    localparam int FRAME_W = PA_W - OFF_W;
    localparam int ENT_SH  = $clog2(ENTRY_W / 8);

    walk_state_t state_q, state_d;
    walk_fault_t fault_q;

    logic [VA_W-1:0]    vaddr_q;
    logic [PA_W-1:0]    root_q;
    logic [PA_W-1:0]    inner_base_q;
    logic [FRAME_W-1:0] frame_q;
    logic [PERM_W-1:0]  perm_q;

    logic               ent_valid;
    logic [FRAME_W-1:0] ent_frame;
    logic [PERM_W-1:0]  ent_perm;
    logic [PA_W-1:0]    outer_addr;
    logic [PA_W-1:0]    inner_addr;
    logic               len_bad;
    logic               accept;

    assign len_bad = req_vaddr[VA_W-1:OFF_W] > tbl_len;
    assign accept  = (state_q == ST_IDLE) && req_valid;

    ptw_entry_decode #(
        .ENTRY_W (ENTRY_W),
        .FRAME_W (FRAME_W),
        .PERM_W  (PERM_W)
    ) u_dec (
        .entry     (mem_rsp_data),
        .ent_valid (ent_valid),
        .ent_frame (ent_frame),
        .ent_perm  (ent_perm)
    );

    ptw_addr_gen #(
        .PA_W  (PA_W),
        .IDX_W (OUT_W),
        .SHIFT (ENT_SH)
    ) u_outer_addr (
        .base (root_q),
        .idx  (vaddr_q[VA_W-1 -: OUT_W]),
        .addr (outer_addr)
    );

    ptw_addr_gen #(
        .PA_W  (PA_W),
        .IDX_W (IN_W),
        .SHIFT (ENT_SH)
    ) u_inner_addr (
        .base (inner_base_q),
        .idx  (vaddr_q[OFF_W +: IN_W]),
        .addr (inner_addr)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (req_valid) state_d = len_bad ? ST_DONE : ST_OUTER_REQ;
            ST_OUTER_REQ:  if (mem_req_ready) state_d = ST_OUTER_WAIT;
            ST_OUTER_WAIT: if (mem_rsp_valid) state_d = ent_valid ? ST_INNER_REQ : ST_DONE;
            ST_INNER_REQ:  if (mem_req_ready) state_d = ST_INNER_WAIT;
            ST_INNER_WAIT: if (mem_rsp_valid) state_d = ST_DONE;
            ST_DONE:       state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // walk context and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_q      <= FLT_NONE;
            vaddr_q      <= '0;
            root_q       <= '0;
            inner_base_q <= '0;
            frame_q      <= '0;
            perm_q       <= '0;
        end else begin
            if (accept) begin
                vaddr_q <= req_vaddr;
                root_q  <= root_base;
                fault_q <= len_bad ? FLT_LENGTH : FLT_NONE;
            end
            if (state_q == ST_OUTER_WAIT && mem_rsp_valid) begin
                if (!ent_valid) fault_q <= FLT_OUTER;
                else            inner_base_q <= {ent_frame, {OFF_W{1'b0}}};
            end
            if (state_q == ST_INNER_WAIT && mem_rsp_valid) begin
                if (!ent_valid) begin
                    fault_q <= FLT_INNER;
                end else begin
                    frame_q <= ent_frame;
                    perm_q  <= ent_perm;
                end
            end
        end
    end

    // outputs
    always_comb begin
        req_ready     = 1'b0;
        mem_req_valid = 1'b0;
        mem_req_addr  = outer_addr;
        done          = 1'b0;
        fault_len     = 1'b0;
        fault_outer   = 1'b0;
        fault_inner   = 1'b0;
        frame         = '0;
        perm          = '0;
        paddr         = '0;
        unique case (state_q)
            ST_IDLE:      req_ready = 1'b1;
            ST_OUTER_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = outer_addr;
            end
            ST_INNER_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = inner_addr;
            end
            ST_DONE: begin
                done        = 1'b1;
                fault_len   = (fault_q == FLT_LENGTH);
                fault_outer = (fault_q == FLT_OUTER);
                fault_inner = (fault_q == FLT_INNER);
                if (fault_q == FLT_NONE) begin
                    frame = frame_q;
                    perm  = perm_q;
                    paddr = {frame_q, vaddr_q[OFF_W-1:0]};
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
    parameter int VA_W  = 32,
    parameter int PA_W  = 32,
    parameter int OFF_W = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic [VA_W-1:0] req_vaddr,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic [PA_W-1:0] mem_req_addr,
    input logic            mem_rsp_valid,
    input logic            done,
    input logic [PA_W-1:0] paddr,
    input logic            fault_len,
    input logic            fault_outer,
    input logic            fault_inner
);
    logic [1:0]       reads_q;
    logic [OFF_W-1:0] off_q;
    logic             any_fault;

    assign any_fault = fault_len | fault_outer | fault_inner;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reads_q <= '0;
            off_q   <= '0;
        end else if (req_valid && req_ready) begin
            reads_q <= '0;
            off_q   <= req_vaddr[OFF_W-1:0];
        end else if (mem_req_valid && mem_req_ready && reads_q != 2'd3) begin
            reads_q <= reads_q + 2'd1;
        end
    end

    a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid || done) |-> !req_ready);

    a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));

    a_r10_one_fault: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fault_len, fault_outer, fault_inner}) && (!any_fault || done));

    a_r2_len_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault_len) |-> (reads_q == 2'd0));

    a_r5_outer_one_read: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault_outer) |-> (reads_q == 2'd1));

    a_r6_inner_two_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault_inner) |-> (reads_q == 2'd2 && paddr == '0));

    a_r7_ok_walk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !any_fault) |-> (reads_q == 2'd2 && paddr[OFF_W-1:0] == off_q));

    a_r4_no_early_resp: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !mem_rsp_valid);

endmodule

bind pt_walker ptw_walker_chk #(
    .VA_W  (VA_W),
    .PA_W  (PA_W),
    .OFF_W (OFF_W)
) u_chk (.*);

// File: tb/tb_pt_walker.sv
`timescale 1ns/1ps
module tb_pt_walker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [31:0] root_base = '0;
    logic [19:0] tbl_len = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        done;
    logic [19:0] frame;
    logic [2:0]  perm;
    logic [31:0] paddr;
    logic        fault_len, fault_outer, fault_inner;

    always #2.5 clk = ~clk;

    pt_walker dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .root_base(root_base), .tbl_len(tbl_len),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .done(done), .frame(frame), .perm(perm),
        .paddr(paddr), .fault_len(fault_len), .fault_outer(fault_outer),
        .fault_inner(fault_inner)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int stall_mode = 0;
    int rsp_lat    = 0;
    int cyc        = 0;

    logic [31:0] mem_img [logic [31:0]];
    logic [31:0] exp_addr_q [$];
    string       exp_tag_q [$];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input bit v, input logic [19:0] fr, input logic [2:0] pm);
        return {v, 8'h00, fr, pm};
    endfunction

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem_img.exists(a) ? mem_img[a] : 32'h0;
    endfunction

    // memory responder: decides ready, checks each accepted read address
    initial begin
        logic [31:0] word;
        bit pending = 0;
        int delay = 0;
        forever begin
            @(negedge clk);
            cyc++;
            mem_rsp_valid = 1'b0;
            if (pending) begin
                if (delay == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = word;
                    pending = 0;
                end else begin
                    delay--;
                end
            end
            mem_req_ready = (stall_mode == 0) ? 1'b1 : ((cyc % 3) == 2);
            if (rst_n && mem_req_valid && mem_req_ready) begin
                if (exp_addr_q.size() == 0) begin
                    chk(0, "R2/R5", "unexpected table read", mem_req_addr, 32'h0);
                end else begin
                    logic [31:0] ea;
                    string tg;
                    ea = exp_addr_q.pop_front();
                    tg = exp_tag_q.pop_front();
                    chk(mem_req_addr == ea, tg, "read address", mem_req_addr, ea);
                end
                word = rd(mem_req_addr);
                pending = 1;
                delay = rsp_lat;
            end
        end
    end

    task automatic do_walk(input logic [31:0] va, input logic [31:0] root,
                           input logic [19:0] len, input string req);
        logic [31:0] oe, ie, oa, ia, e_pa;
        logic [19:0] e_fr;
        logic [2:0]  e_pm;
        bit e_fl, e_fo, e_fi;
        int n;
        e_fl = 0; e_fo = 0; e_fi = 0; e_fr = 0; e_pm = 0; e_pa = 0;
        if (va[31:12] > len) begin
            e_fl = 1;
        end else begin
            oa = root + {20'h0, va[31:22], 2'b00};
            exp_addr_q.push_back(oa); exp_tag_q.push_back("R3");
            oe = rd(oa);
            if (!oe[31]) begin
                e_fo = 1;
            end else begin
                ia = {oe[22:3], 12'h000} + {20'h0, va[21:12], 2'b00};
                exp_addr_q.push_back(ia); exp_tag_q.push_back("R4");
                ie = rd(ia);
                if (!ie[31]) e_fi = 1;
                else begin
                    e_fr = ie[22:3];
                    e_pm = ie[2:0];
                    e_pa = {ie[22:3], va[11:0]};
                end
            end
        end
        @(negedge clk);
        root_base = root; tbl_len = len; req_vaddr = va; req_valid = 1'b1;
        chk(req_ready == 1'b1, "R8", "ready in idle", {31'h0, req_ready}, 32'h1);
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!done && n < 100) begin
            chk(req_ready == 1'b0, "R8", "ready while busy", {31'h0, req_ready}, 32'h0);
            @(negedge clk);
            n++;
        end
        chk(done == 1'b1, req, "done reached", {31'h0, done}, 32'h1);
        chk(req_ready == 1'b0, "R8", "ready in done cycle", {31'h0, req_ready}, 32'h0);
        chk({fault_len, fault_outer, fault_inner} == {e_fl, e_fo, e_fi}, req,
            "fault flags {len,outer,inner}", {29'h0, fault_len, fault_outer, fault_inner},
            {29'h0, e_fl, e_fo, e_fi});
        chk(frame == e_fr, req, "frame", {12'h0, frame}, {12'h0, e_fr});
        chk(perm == e_pm, req, "perm", {29'h0, perm}, {29'h0, e_pm});
        chk(paddr == e_pa, req, "paddr", paddr, e_pa);
        chk(exp_addr_q.size() == 0, req, "all table reads issued", exp_addr_q.size(), 32'h0);
        exp_addr_q.delete(); exp_tag_q.delete();
        @(negedge clk);
        chk(done == 1'b0 && req_ready == 1'b1, "R10", "single done pulse then idle",
            {30'h0, done, req_ready}, 32'h1);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // root A at 0x10000: outer 0 -> inner table 0x20000, outer 1023 -> 0x31000
        mem_img[32'h0001_0000] = mk(1, 20'h00020, 3'b000);
        mem_img[32'h0001_0FFC] = mk(1, 20'h00031, 3'b000);
        mem_img[32'h0002_0014] = mk(1, 20'hABCDE, 3'b101);
        mem_img[32'h0002_001C] = mk(0, 20'h55555, 3'b111);
        mem_img[32'h0003_1FFC] = mk(1, 20'h12345, 3'b111);
        // root B at 0x400000: outer 0 -> inner table 0x70000
        mem_img[32'h0040_0000] = mk(1, 20'h00070, 3'b000);
        mem_img[32'h0007_0014] = mk(1, 20'h00777, 3'b010);

        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1 && done == 1'b0 && mem_req_valid == 1'b0 &&
            {fault_len, fault_outer, fault_inner} == 3'b000, "R1", "state in reset",
            {26'h0, req_ready, done, mem_req_valid, fault_len, fault_outer, fault_inner},
            32'h20);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && done == 1'b0 && mem_req_valid == 1'b0, "R1",
            "state after reset", {29'h0, req_ready, done, mem_req_valid}, 32'h4);

        do_walk(32'h0000_5123, 32'h0001_0000, 20'hFFFFF, "R7");
        do_walk(32'hFFFF_FFFF, 32'h0001_0000, 20'hFFFFF, "R7");
        do_walk(32'h0000_5123, 32'h0040_0000, 20'hFFFFF, "R3");
        do_walk(32'h0080_0000, 32'h0001_0000, 20'hFFFFF, "R5");
        do_walk(32'h0000_6000, 32'h0001_0000, 20'hFFFFF, "R6");
        do_walk(32'h0000_7ABC, 32'h0001_0000, 20'hFFFFF, "R6");
        do_walk(32'h0000_5123, 32'h0001_0000, 20'h00005, "R11");
        do_walk(32'h0000_6000, 32'h0001_0000, 20'h00005, "R2");
        do_walk(32'hFFFF_FFFF, 32'h0001_0000, 20'h00010, "R2");
        stall_mode = 1; rsp_lat = 3;
        do_walk(32'h0000_5123, 32'h0001_0000, 20'hFFFFF, "R9");
        do_walk(32'hFFFF_F000, 32'h0001_0000, 20'hFFFFF, "R4");
        do_walk(32'h0080_0FFF, 32'h0001_0000, 20'hFFFFF, "R5");
        stall_mode = 0; rsp_lat = 1;
        do_walk(32'h0000_7000, 32'h0001_0000, 20'hFFFFF, "R6");
        do_walk(32'h0000_5FFF, 32'h0040_0000, 20'h00005, "R11");
        finish_run();
    end

endmodule